// File: doc/BRIEF.md
# SMBus Bus State and Timeout Monitor

This block listens to the two SMBus wires, the clock line and the data line, after passing each through a two-flop synchronizer. From the synchronized samples it finds START and STOP conditions and keeps a bus state that says whether the bus is in use. It also runs two timers. The idle timer counts cycles in which both lines are high. The low timer counts cycles in which the clock line is low. The block never drives either wire and does not decode any data.

A local transaction engine uses three outputs. `bus_free` tells it whether the bus is free. `start_allowed` is a one-cycle grant for a master START request that is pending. `timeout` and `comm_reset` tell it that a slave has held the clock line low for too long and that it must abandon the current transfer. All thresholds are parameters counted in system clock cycles: `FREE_CYCLES` for the idle time, `LOW_CYCLES` for the clock-low limit and `RESET_DELAY` for the longest wait between timeout detection and the reset request.

The state machine has four states. `ST_BUSY` means the bus is in use and is the state after reset. `ST_FREE` means the bus is idle. `ST_TIMEOUT` means a clock-low timeout has been seen and the reset request is still owed. `ST_HELD` means the reset has been requested and the clock line is still low.

The transitions are:
- BUSY→FREE on a STOP, or when the idle timer expires without a START in the same cycle.
- FREE→BUSY on a START.
- BUSY or FREE→TIMEOUT when the low timer expires.
- TIMEOUT→HELD when the reset pulse is issued because the delay has run out and the clock line is still low.
- TIMEOUT→BUSY when the reset pulse is issued because the clock line was seen high.
- HELD→BUSY when the clock line is seen high.

Top module: `smb_bus_monitor`

## Requirements
- R1: While reset is held and right after it, `bus_free`, `timeout`, `comm_reset` and `start_allowed` are 0. The monitor starts in the busy state. With both lines high, `bus_free` is still 0 after FREE_CYCLES clock edges and becomes 1 after FREE_CYCLES+1 edges.
- R2: A START is SDA going from 1 to 0 while SCL is 1. Both lines pass through two synchronizer flops. A START marks the bus busy, so `bus_free` is 0 three clock edges after the input change.
- R3: A STOP is SDA going from 0 to 1 while SCL is 1. When no timeout is active, a STOP marks the bus free within three clock edges, without waiting for the idle timer.
- R4: The bus also becomes free, with no STOP, once both synchronized lines have been high for FREE_CYCLES consecutive cycles. The state changes on the edge after that, so after a rising SCL with SDA already high, `bus_free` is 0 after FREE_CYCLES+2 edges and 1 after FREE_CYCLES+3 edges. A low sample of either line restarts the count.
- R5: Changes of SDA while SCL is 0 are not START or STOP conditions and leave `bus_free` unchanged. A rising SCL while SDA is 0 also leaves it unchanged.
- R6: `start_allowed` is 1 only when `start_req` is 1, the bus is free and the idle timer has expired. It is 1 for exactly one cycle per request. A request raised while the bus is busy is not granted at the STOP; it is granted only after FREE_CYCLES idle cycles.
- R7: When SCL has been low for LOW_CYCLES consecutive synchronized samples, `timeout` goes to 1 and `bus_free` goes to 0. After SCL falls, `timeout` is 0 after LOW_CYCLES+2 edges and 1 after LOW_CYCLES+3 edges. Any high SCL sample restarts the count.
- R8: Each timeout produces exactly one `comm_reset` pulse, one cycle wide, no more than RESET_DELAY cycles after `timeout` rises. The pulse comes earlier if SCL is seen high before the delay runs out.
- R9: `timeout` stays 1 for as long as SCL stays low. It clears on the third clock edge after SCL rises. The bus is then treated as busy until a STOP or the idle time frees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SMBus clock line level |
| sda_in | input | 1 | Raw SMBus data line level |
| start_req | input | 1 | Level request from the local master to begin a transfer |
| bus_free | output | 1 | Bus is idle (state ST_FREE) |
| start_allowed | output | 1 | One-cycle grant for the pending START request |
| timeout | output | 1 | Clock-low timeout active |
| comm_reset | output | 1 | One-cycle request to reset the transaction engine |

## Verification
The hardest case to reach is the ST_TIMEOUT state being left by a rising clock line before the recovery delay has run out. This case must still give exactly one reset pulse. The bench holds SCL low for exactly LOW_CYCLES+3 edges, then releases it on the next cycle, while the short RESET_DELAY set for the bench has not yet elapsed. A second hard case is a START request raised while the bus is busy: the grant must be held back past the STOP until the idle timer finishes. The bench drives a full START…STOP frame under a held request and counts grant pulses on both sides of the idle threshold.

// File: rtl/smb_mon_pkg.sv
package smb_mon_pkg;

    typedef enum logic [1:0] {
        ST_BUSY    = 2'd0,
        ST_FREE    = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_HELD    = 2'd3
    } bus_state_e;

    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // idle bus level is high, so flops reset to 1
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic both_high
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // data edges count only while the clock line is steady high
    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
    assign both_high = scl_s && sda_s;

endmodule

// File: rtl/smb_timer.sv
module smb_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic done
);
    import smb_mon_pkg::*;

    localparam int CW = cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // saturating up-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (count_en && (cnt != LIM_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM_V);

endmodule

// File: rtl/smb_bus_fsm.sv
module smb_bus_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_s,
    input  logic                     start_det,
    input  logic                     stop_det,
    input  logic                     idle_done,
    input  logic                     low_done,
    input  logic                     rec_done,
    input  logic                     start_req,
    output smb_mon_pkg::bus_state_e  state,
    output logic                     bus_free,
    output logic                     start_allowed,
    output logic                     timeout,
    output logic                     comm_reset
);
    import smb_mon_pkg::*;

    bus_state_e state_nx;
    logic       granted;
    logic       grant_now;

    // state register and grant memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_BUSY;
            granted <= 1'b0;
        end else begin
            state <= state_nx;
            if (!start_req) begin
                granted <= 1'b0;
            end else if (grant_now) begin
                granted <= 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BUSY: begin
                if (low_done) begin
                    state_nx = ST_TIMEOUT;
                end else if (start_det) begin
                    state_nx = ST_BUSY;
                end else if (stop_det || idle_done) begin
                    state_nx = ST_FREE;
                end
            end
            ST_FREE: begin
                if (low_done) begin
                    state_nx = ST_TIMEOUT;
                end else if (start_det) begin
                    state_nx = ST_BUSY;
                end
            end
            ST_TIMEOUT: begin
                if (scl_s) begin
                    state_nx = ST_BUSY;
                end else if (rec_done) begin
                    state_nx = ST_HELD;
                end
            end
            ST_HELD: begin
                if (scl_s) begin
                    state_nx = ST_BUSY;
                end
            end
        endcase
    end

    // output decode
    always_comb begin
        bus_free   = 1'b0;
        timeout    = 1'b0;
        comm_reset = 1'b0;
        grant_now  = 1'b0;
        unique case (state)
            ST_BUSY: begin
            end
            ST_FREE: begin
                bus_free  = 1'b1;
                grant_now = start_req && idle_done && !granted;
            end
            ST_TIMEOUT: begin
                timeout    = 1'b1;
                comm_reset = scl_s || rec_done;
            end
            ST_HELD: begin
                timeout = 1'b1;
            end
        endcase
        start_allowed = grant_now;
    end

endmodule

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int FREE_CYCLES = 1250,
    parameter int LOW_CYCLES  = 625000,
    parameter int RESET_DELAY = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_req,
    output logic bus_free,
    output logic start_allowed,
    output logic timeout,
    output logic comm_reset
);
    import smb_mon_pkg::*;

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       start_det;
    logic       stop_det;
    logic       both_high;
    logic       idle_done;
    logic       low_done;
    logic       rec_done;
    bus_state_e state;

    smb_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_in, sda_in}),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    smb_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .both_high (both_high)
    );

    smb_timer #(.LIMIT(FREE_CYCLES)) u_idle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!both_high),
        .count_en (1'b1),
        .done     (idle_done)
    );

    smb_timer #(.LIMIT(LOW_CYCLES)) u_low_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (scl_s),
        .count_en (1'b1),
        .done     (low_done)
    );

    smb_timer #(.LIMIT(RESET_DELAY)) u_rec_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state != ST_TIMEOUT),
        .count_en (1'b1),
        .done     (rec_done)
    );

    smb_bus_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_s         (scl_s),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .idle_done     (idle_done),
        .low_done      (low_done),
        .rec_done      (rec_done),
        .start_req     (start_req),
        .state         (state),
        .bus_free      (bus_free),
        .start_allowed (start_allowed),
        .timeout       (timeout),
        .comm_reset    (comm_reset)
    );

endmodule

// File: rtl/smb_bus_monitor_chk.sv
module smb_bus_monitor_chk #(
    parameter int RESET_DELAY = 125000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic start_req,
    input logic bus_free,
    input logic start_allowed,
    input logic timeout,
    input logic comm_reset
);

    int wait_cnt;
    logic reset_seen;

    // cycles spent in timeout before its reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt   <= 0;
            reset_seen <= 1'b0;
        end else if (!timeout) begin
            wait_cnt   <= 0;
            reset_seen <= 1'b0;
        end else if (comm_reset || reset_seen) begin
            wait_cnt   <= 0;
            reset_seen <= 1'b1;
        end else begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_free);

    p_free_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !timeout) |=> bus_free);

    p_grant_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_allowed |-> (bus_free && start_req));

    p_grant_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_allowed |=> !start_allowed);

    p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comm_reset |=> !comm_reset);

    p_reset_in_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comm_reset |-> timeout);

    p_reset_deadline_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= RESET_DELAY);

    p_timeout_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !scl_s) |=> timeout);

endmodule

bind smb_bus_monitor smb_bus_monitor_chk #(.RESET_DELAY(RESET_DELAY)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .start_req     (start_req),
    .bus_free      (bus_free),
    .start_allowed (start_allowed),
    .timeout       (timeout),
    .comm_reset    (comm_reset)
);

// File: tb/test_smb_bus_monitor.sv
`timescale 1ns/1ps
module test_smb_bus_monitor;

    localparam int F = 20;
    localparam int L = 60;
    localparam int D = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic req = 1'b0;
    logic bus_free, start_allowed, timeout, comm_reset;

    int tests = 0;
    int fails = 0;
    int n_rst = 0;
    int n_grant = 0;
    int snap;

    always #2 clk = ~clk;

    smb_bus_monitor #(
        .SYNC_STAGES (2),
        .FREE_CYCLES (F),
        .LOW_CYCLES  (L),
        .RESET_DELAY (D)
    ) i_smb_bus_monitor (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (scl),
        .sda_in        (sda),
        .start_req     (req),
        .bus_free      (bus_free),
        .start_allowed (start_allowed),
        .timeout       (timeout),
        .comm_reset    (comm_reset)
    );

    always @(posedge clk) begin
        if (comm_reset)    n_rst   <= n_rst + 1;
        if (start_allowed) n_grant <= n_grant + 1;
    end

    // {scl, sda, exp_free, exp_timeout, hold}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd4},  // idle, free
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd4},  // START
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd4},  // data change, SCL low
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd4},  // SCL rise, short high
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd4},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd4},  // data change, SCL low
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd4},  // SCL rise, SDA low
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd4},  // STOP
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd4},  // START
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd4},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd4},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd4}   // STOP
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_n(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(4ns * 200000);
        fails++;
        $display("FAIL watchdog: got running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state and first bus-free via idle time
        tick(3);
        chk("R1 bus_free in reset", bus_free, 1'b0);
        chk("R1 timeout in reset", timeout, 1'b0);
        chk("R1 comm_reset in reset", comm_reset, 1'b0);
        rst_n = 1'b1;
        tick(F);
        chk("R1 busy before idle limit", bus_free, 1'b0);
        tick(1);
        chk("R1 free after idle limit", bus_free, 1'b1);

        // table: R2 start, R3 stop, R5 data moves with SCL low
        for (int i = 0; i < NV; i++) begin
            scl = VEC[i][11];
            sda = VEC[i][10];
            tick(int'(VEC[i][7:0]));
            chk($sformatf("R2/R3/R5 vector %0d bus_free", i), bus_free, VEC[i][9]);
            chk($sformatf("R5 vector %0d timeout", i), timeout, VEC[i][8]);
        end

        // R2 exact latency of START
        sda = 1'b0;
        tick(2);
        chk("R2 still free after two edges", bus_free, 1'b1);
        tick(1);
        chk("R2 busy on third edge", bus_free, 1'b0);

        // R4 idle restart on SCL low sample
        scl = 1'b0; tick(4);
        sda = 1'b1; tick(4);
        scl = 1'b1; tick(F - 5);
        chk("R4 busy before idle", bus_free, 1'b0);
        scl = 1'b0; tick(4);
        scl = 1'b1; tick(F - 5);
        chk("R4 idle count restarted", bus_free, 1'b0);
        tick(10);
        chk("R4 free after full idle", bus_free, 1'b1);

        // R4 exact idle threshold with no STOP
        sda = 1'b0; tick(4);
        scl = 1'b0; tick(4);
        sda = 1'b1; tick(4);
        scl = 1'b1; tick(F + 2);
        chk("R4 busy at idle edge", bus_free, 1'b0);
        tick(1);
        chk("R4 free one edge later", bus_free, 1'b1);

        // R6 grant only after idle time, single pulse
        sda = 1'b0; tick(4);
        scl = 1'b0; tick(4);
        scl = 1'b1; tick(4);
        sda = 1'b1;
        tick(3);
        snap = n_grant;
        req = 1'b1;
        #1;
        chk("R6 free after STOP", bus_free, 1'b1);
        chk("R6 no grant before idle", start_allowed, 1'b0);
        tick(F + 6);
        chk_n("R6 one grant after idle", n_grant - snap, 1);
        req = 1'b0; tick(1);
        req = 1'b1; #1;
        chk("R6 immediate grant when idle", start_allowed, 1'b1);
        tick(1);
        chk("R6 grant is single cycle", start_allowed, 1'b0);

        // R6 request raised while busy waits past STOP
        req = 1'b0; tick(1);
        sda = 1'b0; tick(4);
        req = 1'b1;
        scl = 1'b0; tick(4);
        scl = 1'b1; tick(4);
        snap = n_grant;
        sda = 1'b1;
        tick(3);
        chk("R6 free right after STOP", bus_free, 1'b1);
        chk_n("R6 no grant at STOP", n_grant - snap, 0);
        tick(F + 4);
        chk_n("R6 grant after idle", n_grant - snap, 1);
        req = 1'b0;

        // R7 low count restarted by a high sample
        sda = 1'b0; tick(4);
        scl = 1'b0; tick(L - 10);
        scl = 1'b1; tick(3);
        scl = 1'b0; tick(L - 10);
        chk("R7 low count restarted", timeout, 1'b0);
        scl = 1'b1; tick(4);

        // R7 exact threshold, R8 pulse, R9 hold and release
        snap = n_rst;
        scl = 1'b0;
        tick(L + 2);
        chk("R7 no timeout at limit edge", timeout, 1'b0);
        tick(1);
        chk("R7 timeout set", timeout, 1'b1);
        chk("R7 bus not free in timeout", bus_free, 1'b0);
        tick(D + 2);
        chk_n("R8 one reset pulse", n_rst - snap, 1);
        chk("R9 timeout held", timeout, 1'b1);
        tick(20);
        chk_n("R8 no extra pulse", n_rst - snap, 1);
        scl = 1'b1;
        tick(2);
        chk("R9 timeout until sync", timeout, 1'b1);
        tick(1);
        chk("R9 timeout clears", timeout, 1'b0);
        chk("R9 busy after timeout", bus_free, 1'b0);
        sda = 1'b1;
        tick(3);
        chk("R9 STOP frees after timeout", bus_free, 1'b1);

        // R8 early release before the delay runs out
        sda = 1'b0; tick(4);
        snap = n_rst;
        scl = 1'b0;
        tick(L + 3);
        chk("R8 timeout before early release", timeout, 1'b1);
        scl = 1'b1;
        tick(4);
        chk_n("R8 pulse on early release", n_rst - snap, 1);
        chk("R9 timeout cleared on release", timeout, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule